// File: doc/BRIEF.md
# Software Write-Lock Command Detector

This block sits on the write path in front of a nonvolatile memory model. It sees every bus write to the memory as an address and a byte. For each write it decides whether that write may reach the array. It also keeps one state bit that locks the array against software writes. Storage, programming time and analog effects belong to other blocks.

Two command sequences of different lengths drive the lock. The shorter one is three command writes followed by one real data write. That data write is committed, and the lock turns on with it. The longer one is six command writes. It turns the lock off, and none of its bytes are committed. Command addresses are matched on the low 15 address bits only. A separate timer supplies a strobe that abandons a sequence that has stalled part way.

Each write returns a verdict one clock later: a response pulse together with a commit flag. The lock bit changes on the same edge as the verdict of the write that caused the change.

Top module: `swp_guard`

## Requirements
- R1: During reset and after it, the lock output is 0 and no response is issued.
- R2: Each cycle with `wr_valid` high produces exactly one cycle of `rsp_valid` on the next clock edge. `rsp_commit` can be 1 only while `rsp_valid` is 1.
- R3: While unlocked, a write that does not continue a command sequence is committed.
- R4: The enable sequence is: low15 address 0x5555 with data 0xAA, then 0x2AAA with 0x55, then 0x5555 with 0xA0, then any data write. The three command writes are not committed. The fourth write is committed, and the lock is 1 from its verdict onward.
- R5: While locked, a write that does not continue a command sequence is not committed.
- R6: While locked, a write preceded by the full three-write enable prefix is committed, and the lock stays 1.
- R7: The disable sequence is: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x20. None of its six writes is committed. The lock goes to 0 with the verdict of the sixth write and stays 1 before that.
- R8: Only address bits [14:0] are compared, so addresses 0xAAAA and 0x1D555 match 0x2AAA and 0x5555 respectively.
- R9: A write that breaks a partial sequence returns the detector to idle. That write is committed if unlocked and dropped if locked.
- R10: A timeout strobe abandons any partial sequence, including a complete three-write prefix, and leaves the lock unchanged. The next write is then judged from idle.
- R11: The lock output changes only on the clock edge that follows a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A bus write is presented this cycle |
| wr_addr | input | ADDR_W (17) | Write address |
| wr_data | input | 8 | Write data byte |
| tmo_strobe | input | 1 | Inter-byte timeout from the external timer |
| rsp_valid | output | 1 | Verdict for the write of the previous cycle |
| rsp_commit | output | 1 | That write may be written to the array |
| lock_on | output | 1 | Software write lock is active |

## Verification
A detector stuck in the wrong sequence step shows up at the ports within one write. A data write is committed or dropped against the rule for the current lock state, or the lock bit flips one step too early or too late in a sequence. A lock bit that fails to set or clear shows on the very next ordinary write. The commit flag of that write inverts. Timeout and mismatch handling are tested by following every aborted sequence with the write that would otherwise finish it. That write must be judged from idle.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int BYTE_W     = 8;
    localparam int CMD_ADDR_W = 15;

    localparam logic [CMD_ADDR_W-1:0] ADDR_LEAD = 15'h5555;
    localparam logic [CMD_ADDR_W-1:0] ADDR_MID  = 15'h2AAA;

    localparam logic [BYTE_W-1:0] D_KEY1  = 8'hAA;
    localparam logic [BYTE_W-1:0] D_KEY2  = 8'h55;
    localparam logic [BYTE_W-1:0] D_ARM   = 8'hA0;
    localparam logic [BYTE_W-1:0] D_EXT   = 8'h80;
    localparam logic [BYTE_W-1:0] D_CLEAR = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE, ST_K1, ST_K2, ST_ARMED, ST_X1, ST_X2, ST_X3
    } seq_state_t;

    typedef enum logic [2:0] {
        TOK_NONE, TOK_LEAD_KEY1, TOK_MID_KEY2, TOK_LEAD_ARM, TOK_LEAD_EXT, TOK_LEAD_CLEAR
    } tok_t;

    typedef struct packed {
        logic valid;
        logic commit;
    } verdict_t;

    function automatic tok_t classify(logic [CMD_ADDR_W-1:0] a, logic [BYTE_W-1:0] d);
        tok_t t;
        t = TOK_NONE;
        if (a == ADDR_LEAD) begin
            if (d == D_KEY1)       t = TOK_LEAD_KEY1;
            else if (d == D_ARM)   t = TOK_LEAD_ARM;
            else if (d == D_EXT)   t = TOK_LEAD_EXT;
            else if (d == D_CLEAR) t = TOK_LEAD_CLEAR;
        end else if (a == ADDR_MID && d == D_KEY2) begin
            t = TOK_MID_KEY2;
        end
        return t;
    endfunction

endpackage

// File: rtl/swp_tok_decode.sv
module swp_tok_decode
    import swp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    output tok_t              tok
);
    // Only the low command-address bits take part in the compare (R8).
    logic [CMD_ADDR_W-1:0] low_addr;
    assign low_addr = addr[CMD_ADDR_W-1:0];
    assign tok      = classify(low_addr, data);

    // Upper address bits are deliberately ignored.
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:CMD_ADDR_W];

endmodule

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm
    import swp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_valid,
    input  logic tmo_strobe,
    input  tok_t tok,
    output logic commit_now,
    output logic lock_q
);
    seq_state_t st_q, st_d, st_eff;
    logic       lock_d;

    always_comb begin
        // A timeout abandons any partial sequence before the write is judged.
        st_eff     = tmo_strobe ? ST_IDLE : st_q;
        st_d       = st_eff;
        lock_d     = lock_q;
        commit_now = 1'b0;
        if (wr_valid) begin
            unique case (st_eff)
                ST_IDLE: begin
                    if (tok == TOK_LEAD_KEY1) st_d = ST_K1;
                    else                      commit_now = !lock_q;
                end
                ST_K1: begin
                    if (tok == TOK_MID_KEY2) st_d = ST_K2;
                    else begin st_d = ST_IDLE; commit_now = !lock_q; end
                end
                ST_K2: begin
                    if (tok == TOK_LEAD_ARM)      st_d = ST_ARMED;
                    else if (tok == TOK_LEAD_EXT) st_d = ST_X1;
                    else begin st_d = ST_IDLE; commit_now = !lock_q; end
                end
                ST_ARMED: begin
                    st_d       = ST_IDLE;
                    commit_now = 1'b1;
                    lock_d     = 1'b1;
                end
                ST_X1: begin
                    if (tok == TOK_LEAD_KEY1) st_d = ST_X2;
                    else begin st_d = ST_IDLE; commit_now = !lock_q; end
                end
                ST_X2: begin
                    if (tok == TOK_MID_KEY2) st_d = ST_X3;
                    else begin st_d = ST_IDLE; commit_now = !lock_q; end
                end
                ST_X3: begin
                    st_d = ST_IDLE;
                    if (tok == TOK_LEAD_CLEAR) lock_d = 1'b0;
                    else                       commit_now = !lock_q;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            lock_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            lock_q <= lock_d;
        end
    end

    // R1: reset leaves the lock off
    p_reset_unlocked_r1: assert property (@(posedge clk) rst |=> !lock_q);

    // R11: no write, no lock change
    p_lock_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable(lock_q));

    // R10: a lone timeout strobe never changes the lock
    p_tmo_no_lock_r10: assert property (@(posedge clk) disable iff (rst)
        (tmo_strobe && !wr_valid) |=> $stable(lock_q));

endmodule

// File: rtl/swp_rsp_reg.sv
module swp_rsp_reg
    import swp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic     in_commit,
    output verdict_t rsp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid  <= in_valid;
            rsp.commit <= in_valid & in_commit;
        end
    end
endmodule

// File: rtl/swp_guard.sv
module swp_guard
    import swp_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              tmo_strobe,
    output logic              rsp_valid,
    output logic              rsp_commit,
    output logic              lock_on
);
    tok_t     tok;
    logic     commit_now;
    verdict_t verdict;

    swp_tok_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (wr_addr),
        .data (wr_data),
        .tok  (tok)
    );

    swp_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .tmo_strobe (tmo_strobe),
        .tok        (tok),
        .commit_now (commit_now),
        .lock_q     (lock_on)
    );

    swp_rsp_reg u_rsp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (wr_valid),
        .in_commit (commit_now),
        .rsp       (verdict)
    );

    assign rsp_valid  = verdict.valid;
    assign rsp_commit = verdict.commit;

    // R2: one verdict per write, on the next edge
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> rsp_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> !rsp_valid);
    p_commit_in_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_commit |-> rsp_valid);

    // R4: the lock turns on together with a committed write
    p_lock_rise_commits_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_on) |-> (rsp_valid && rsp_commit));

    // R7: the lock turns off together with a dropped write
    p_lock_fall_drops_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_on) |-> (rsp_valid && !rsp_commit));

endmodule

// File: tb/tb_swp_guard.sv
`timescale 1ns/1ps
module tb_swp_guard;
    localparam int ADDR_W = 17;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              tmo_strobe;
    logic              rsp_valid, rsp_commit, lock_on;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    swp_guard #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .tmo_strobe(tmo_strobe), .rsp_valid(rsp_valid),
        .rsp_commit(rsp_commit), .lock_on(lock_on)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One write; verdict sampled at the negedge after the capturing edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                      input logic exp_commit, input logic exp_lock, input string req);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R2", "rsp_valid", rsp_valid, 1'b1);
        chk(req, "commit", rsp_commit, exp_commit);
        chk(req, "lock", lock_on, exp_lock);
    endtask

    task automatic tmo_pulse(input logic exp_lock);
        @(negedge clk);
        tmo_strobe = 1'b1;
        @(negedge clk);
        tmo_strobe = 1'b0;
        chk("R11", "no rsp on idle", rsp_valid, 1'b0);
        chk("R10", "lock after timeout", lock_on, exp_lock);
    endtask

    task automatic t_reset;
        rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; tmo_strobe = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "lock in reset", lock_on, 1'b0);
        chk("R1", "rsp in reset", rsp_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "lock after reset", lock_on, 1'b0);
        chk("R1", "no rsp after reset", rsp_valid, 1'b0);
    endtask

    task automatic t_plain_unlocked;
        wr(17'h00100, 8'h3C, 1'b1, 1'b0, "R3");
        wr(17'h05555, 8'h12, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_prefix_timeout;
        wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R4");
        wr(17'h02AAA, 8'h55, 1'b0, 1'b0, "R4");
        wr(17'h05555, 8'hA0, 1'b0, 1'b0, "R4");
        tmo_pulse(1'b0);
        wr(17'h00200, 8'h11, 1'b1, 1'b0, "R10");
        wr(17'h00210, 8'h12, 1'b1, 1'b0, "R10");
    endtask

    task automatic t_mismatch_unlocked;
        wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R9");
        wr(17'h02AAA, 8'h56, 1'b1, 1'b0, "R9");
        wr(17'h05555, 8'hA0, 1'b1, 1'b0, "R9");
    endtask

    task automatic t_enable_alt_addr;
        wr(17'h05555, 8'hAA, 1'b0, 1'b0, "R4");
        wr(17'h0AAAA, 8'h55, 1'b0, 1'b0, "R8");
        wr(17'h05555, 8'hA0, 1'b0, 1'b0, "R4");
        wr(17'h00400, 8'h77, 1'b1, 1'b1, "R4");
    endtask

    task automatic t_locked_drop;
        wr(17'h00500, 8'h01, 1'b0, 1'b1, "R5");
        wr(17'h05555, 8'hAA, 1'b0, 1'b1, "R9");
        wr(17'h02AAA, 8'h99, 1'b0, 1'b1, "R9");
        wr(17'h05555, 8'hA0, 1'b0, 1'b1, "R9");
        wr(17'h00600, 8'h02, 1'b0, 1'b1, "R5");
    endtask

    task automatic t_locked_prefix;
        wr(17'h1D555, 8'hAA, 1'b0, 1'b1, "R8");
        wr(17'h02AAA, 8'h55, 1'b0, 1'b1, "R6");
        wr(17'h05555, 8'hA0, 1'b0, 1'b1, "R6");
        wr(17'h00700, 8'h5A, 1'b1, 1'b1, "R6");
        wr(17'h00710, 8'h5B, 1'b0, 1'b1, "R5");
    endtask

    task automatic t_locked_timeout;
        wr(17'h05555, 8'hAA, 1'b0, 1'b1, "R10");
        wr(17'h02AAA, 8'h55, 1'b0, 1'b1, "R10");
        tmo_pulse(1'b1);
        wr(17'h05555, 8'hA0, 1'b0, 1'b1, "R10");
        wr(17'h00800, 8'h03, 1'b0, 1'b1, "R10");
    endtask

    task automatic t_disable;
        wr(17'h05555, 8'hAA, 1'b0, 1'b1, "R7");
        wr(17'h02AAA, 8'h55, 1'b0, 1'b1, "R7");
        wr(17'h05555, 8'h80, 1'b0, 1'b1, "R7");
        wr(17'h05555, 8'hAA, 1'b0, 1'b1, "R7");
        wr(17'h0AAAA, 8'h55, 1'b0, 1'b1, "R7");
        wr(17'h05555, 8'h20, 1'b0, 1'b0, "R7");
        wr(17'h00900, 8'h44, 1'b1, 1'b0, "R7");
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual expired expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_plain_unlocked();
        t_prefix_timeout();
        t_mismatch_unlocked();
        t_enable_alt_addr();
        t_locked_drop();
        t_locked_prefix();
        t_locked_timeout();
        t_disable();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule